// File: doc/BRIEF.md
# PSE Type and Power Allocation Indicator Controller

This block lives inside a powered-device controller and drives three open-drain status indicators. Two of them carry a two-bit code for the power the sourcing equipment has granted. That code follows the number of classification cycles the device actually received during startup, not the class it asked for. The third indicator tells whether the sourcing equipment is a higher-power type (Type 3-4) or a legacy one (Type 1-2). The classification count and the type flag are captured once when classification ends. They stay held until the supply drops below the mark-reset level.

The indicators stay disabled (high impedance) until a settle delay, counted in clock ticks, has run out after startup. Startup is marked either by the converter-input-good qualifier rising, or by power-good being released while that qualifier is already high. Thermal shutdown, converter-output undervoltage or a supply below the operating level disables the indicators at once. The held code survives these faults. It is shown again only after a fresh startup event and a full settle delay.

Each indicator is a pair of signals: an output enable and a pull-down. An enabled indicator whose pull-down is off reads "high". An enabled indicator whose pull-down is on reads "low". An indicator whose enable is off is high impedance.

Top module: `poe_type_indicator`

## Requirements
- R1: The power code on `ind_pull[2:1]` follows the latched cycle count: 0 or 1 cycles give 2'b00, 2 or 3 give 2'b01, 4 gives 2'b10, and 5 gives 2'b11 (1 = pull low). The count saturates at 5, so six or more pulses read as 5.
- R2: `ind_pull[0]` (the type indicator) is 1 (pulled low) when `pse_type34` was 1 at the end of classification, and 0 otherwise, whatever the count.
- R3: A `cls_pulse` in the same cycle as `cls_done` is still counted. Pulses after that cycle have no effect until the next mark reset.
- R4: After the clock edge that registers a start event, `ind_oe` stays 3'b000 for DELAY_TICKS-1 further edges and becomes 3'b111 on the DELAY_TICKS-th edge.
- R5: A rising `pg_released` while `vc_in_good` is already high is also a start event. A rise of `vc_in_good` is always a start event. A new start event restarts the delay.
- R6: When `therm_sd`, `vcout_uv`, `supply_low` or `supply_below_mark` is high at a clock edge, `ind_oe` and `ind_pull` are 3'b000 after that edge. A fault beats a start event registered at the same edge.
- R7: Faults other than the mark reset keep the latched count and type. After the next start event and a full delay, the same code is driven again.
- R8: `supply_below_mark` clears the latched count, the type and the classification-done state. Without a new classification, the next enable shows 3'b000 on `ind_pull`.
- R9: A fault during the settle delay aborts it. The indicators stay disabled after the fault clears until a new start event and a full delay.
- R10: `ind_pull` is never set on an indicator whose `ind_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the tick for the settle delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| cls_pulse | input | 1 | One-cycle strobe per classification cycle received |
| cls_done | input | 1 | Classification finished; latches count and type |
| pse_type34 | input | 1 | 1 = sourcing equipment is Type 3-4 |
| vc_in_good | input | 1 | Converter input is above its good level |
| pg_released | input | 1 | Power-good output released (inrush finished) |
| therm_sd | input | 1 | Thermal shutdown active |
| vcout_uv | input | 1 | Converter output below its undervoltage level |
| supply_low | input | 1 | Supply below the operating level |
| supply_below_mark | input | 1 | Supply below the mark-reset level |
| ind_pull | output | 3 | Pull-down per indicator: [2] power high bit, [1] power low bit, [0] type |
| ind_oe | output | 3 | Enable per indicator; 0 = high impedance |

## Verification
Two events can fall in the same cycle: the settle-delay start and a fault, and the last classification pulse and the end-of-classification strobe. Directed cases raise a start event and a thermal fault on the same edge, and expect the indicators to stay disabled through a later wait longer than the delay. They also put a pulse on the same edge as the done strobe, and expect the count to include it. Randomised rounds mix pulse counts from zero to seven, types, extra pulses after done, and fault kinds and lengths. Each round compares the enable timing and the driven code with a bench model of the count-to-code table.

// File: rtl/poe_ind_pkg.sv
package poe_ind_pkg;
  localparam int unsigned MAX_CLS_CYCLES = 5;
  localparam int unsigned CLS_CNT_W      = $clog2(MAX_CLS_CYCLES + 1);
  localparam int unsigned IND_N          = 3;
  localparam int unsigned IDX_PWR_HI     = 2;
  localparam int unsigned IDX_PWR_LO     = 1;
  localparam int unsigned IDX_TYPE       = 0;

  typedef logic [CLS_CNT_W-1:0] cls_cnt_t;

  // Two-bit power code, 1 = pull that indicator low.
  // A zero count is shown like one cycle so no invalid code appears.
  function automatic logic [1:0] power_code(cls_cnt_t n);
    int unsigned v;
    v = int'(n);
    if (v <= 1)      power_code = 2'b00;
    else if (v <= 3) power_code = 2'b01;
    else if (v == 4) power_code = 2'b10;
    else             power_code = 2'b11;
  endfunction

  function automatic logic [IND_N-1:0] pull_vector(logic [1:0] pc, logic type34);
    pull_vector = '0;
    pull_vector[IDX_PWR_HI] = pc[1];
    pull_vector[IDX_PWR_LO] = pc[0];
    pull_vector[IDX_TYPE]   = type34;
  endfunction
endpackage

// File: rtl/cls_counter.sv
module cls_counter
  import poe_ind_pkg::*;
#(
  parameter int unsigned MAX_CYCLES = MAX_CLS_CYCLES
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear,
  input  logic     pulse,
  input  logic     done_in,
  input  logic     type_in,
  output cls_cnt_t cnt,
  output logic     done_q,
  output logic     type_q
);
  localparam cls_cnt_t CNT_MAX = cls_cnt_t'(MAX_CYCLES);

  logic accept;
  logic at_max;

  assign at_max = (cnt == CNT_MAX);
  assign accept = pulse && !done_q && !clear && !at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_q <= 1'b0;
      type_q <= 1'b0;
    end else if (clear) begin
      cnt    <= '0;
      done_q <= 1'b0;
      type_q <= 1'b0;
    end else begin
      if (accept) cnt <= cnt + cls_cnt_t'(1);
      if (done_in && !done_q) begin
        done_q <= 1'b1;
        type_q <= type_in;
      end
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX); // R1
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clear) |=> $stable(cnt) && $stable(type_q)); // R3
  AST_MARK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0) && !done_q && !type_q); // R8
endmodule

// File: rtl/startup_detect.sv
module startup_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic vc_in_good,
  input  logic pg_released,
  output logic start_evt
);
  logic vc_q;
  logic pg_q;
  logic vc_rise;
  logic pg_rise_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vc_q <= 1'b0;
      pg_q <= 1'b0;
    end else begin
      vc_q <= vc_in_good;
      pg_q <= pg_released;
    end
  end

  assign vc_rise      = vc_in_good && !vc_q;
  // converter input already up when power-good is released
  assign pg_rise_late = pg_released && !pg_q && vc_in_good && vc_q;
  assign start_evt    = vc_rise || pg_rise_late;
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned DELAY_TICKS = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  output logic running,
  output logic ready
);
  localparam int unsigned TW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(DELAY_TICKS - 1);

  logic [TW-1:0] tcnt;
  logic          expire;

  assign expire = running && (tcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ready   <= 1'b0;
      tcnt    <= '0;
    end else if (abort) begin
      running <= 1'b0;
      ready   <= 1'b0;
      tcnt    <= '0;
    end else if (start) begin
      running <= 1'b1;
      ready   <= 1'b0;
      tcnt    <= '0;
    end else if (expire) begin
      running <= 1'b0;
      ready   <= 1'b1;
      tcnt    <= '0;
    end else if (running) begin
      tcnt    <= tcnt + TW'(1);
    end
  end

  AST_ABORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !ready && !running); // R9
  AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> running && !ready); // R4
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && ready)); // R4
endmodule

// File: rtl/poe_type_indicator.sv
module poe_type_indicator
  import poe_ind_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 24000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cls_pulse,
  input  logic             cls_done,
  input  logic             pse_type34,
  input  logic             vc_in_good,
  input  logic             pg_released,
  input  logic             therm_sd,
  input  logic             vcout_uv,
  input  logic             supply_low,
  input  logic             supply_below_mark,
  output logic [IND_N-1:0] ind_pull,
  output logic [IND_N-1:0] ind_oe
);
  cls_cnt_t         cls_cnt;
  logic             cls_done_q;
  logic             type_q;
  logic             start_evt;
  logic             fault_any;
  logic             delay_running;
  logic             ind_ready;
  logic [1:0]       pcode;
  logic [IND_N-1:0] pull_want;

  assign fault_any = therm_sd || vcout_uv || supply_low || supply_below_mark;

  cls_counter #(.MAX_CYCLES(MAX_CLS_CYCLES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (supply_below_mark),
    .pulse   (cls_pulse),
    .done_in (cls_done),
    .type_in (pse_type34),
    .cnt     (cls_cnt),
    .done_q  (cls_done_q),
    .type_q  (type_q)
  );

  startup_detect u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .vc_in_good  (vc_in_good),
    .pg_released (pg_released),
    .start_evt   (start_evt)
  );

  settle_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort   (fault_any),
    .start   (start_evt),
    .running (delay_running),
    .ready   (ind_ready)
  );

  assign pcode     = power_code(cls_cnt);
  assign pull_want = pull_vector(pcode, type_q);

  // open-drain output pairs, one per indicator
  for (genvar i = 0; i < IND_N; i++) begin : g_od
    assign ind_oe[i]   = ind_ready;
    assign ind_pull[i] = ind_ready && pull_want[i];
  end

  AST_FAULT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> (ind_oe == '0) && (ind_pull == '0)); // R6
  AST_PULL_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_pull & ~ind_oe) == '0); // R10
  AST_TYPE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_done_q |-> !type_q); // R2
  AST_DELAY_BLOCKS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    delay_running |-> (ind_oe == '0)); // R4
endmodule

// File: tb/poe_type_indicator_test.sv
module poe_type_indicator_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cls_pulse = 0, cls_done = 0, pse_type34 = 0;
  logic vc_in_good = 0, pg_released = 0;
  logic therm_sd = 0, vcout_uv = 0, supply_low = 0, supply_below_mark = 0;
  logic [2:0] ind_pull, ind_oe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  poe_type_indicator #(.DELAY_TICKS(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .cls_pulse(cls_pulse), .cls_done(cls_done),
    .pse_type34(pse_type34), .vc_in_good(vc_in_good), .pg_released(pg_released),
    .therm_sd(therm_sd), .vcout_uv(vcout_uv), .supply_low(supply_low),
    .supply_below_mark(supply_below_mark), .ind_pull(ind_pull), .ind_oe(ind_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL R4 watchdog expired act=%0d exp<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // model: saturated count to pull bits {hi, lo, type}
  function automatic logic [2:0] exp_pull(int n, logic t);
    int s;
    logic hi, lo;
    s = (n > 5) ? 5 : n;
    case (s)
      4:       begin hi = 1; lo = 0; end
      5:       begin hi = 1; lo = 1; end
      2, 3:    begin hi = 0; lo = 1; end
      default: begin hi = 0; lo = 0; end
    endcase
    return {hi, lo, t};
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b (pull,oe)", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      cls_pulse = 1; step();
      cls_pulse = 0; step($urandom % 3);
    end
  endtask

  task automatic finish_cls(logic t);
    pse_type34 = t; cls_done = 1; step();
    cls_done = 0; pse_type34 = $urandom % 2;
  endtask

  task automatic mark_reset();
    supply_below_mark = 1; step();
    supply_below_mark = 0; step();
  endtask

  // start event applied: expect off after DLY edges, on after DLY+1
  task automatic await_enable(string req, logic [2:0] p);
    step(DLY);
    chk(req, {ind_pull, ind_oe}, 6'b000000);
    step();
    chk(req, {ind_pull, ind_oe}, {p, 3'b111});
  endtask

  initial begin
    void'($urandom(32'd7741));
    step(2);
    chk("R6 reset", {ind_pull, ind_oe}, 6'b0);
    rst_n = 1; step(2);
    chk("R4 idle", {ind_pull, ind_oe}, 6'b0);

    // zero cycles, no done: (high,high,high)
    vc_in_good = 1;
    await_enable("R1_zero R4", 3'b000);
    vc_in_good = 0; step(2);

    // pulse coincident with done is counted: 3 pulses total -> 2'b01
    mark_reset();
    pulses(2);
    cls_pulse = 1; pse_type34 = 1; cls_done = 1; step();
    cls_pulse = 0; cls_done = 0; pse_type34 = 0;
    pulses(3);
    vc_in_good = 1;
    await_enable("R3 R2", 3'b011);

    // mark reset clears latched state
    mark_reset();
    chk("R6 mark", {ind_pull, ind_oe}, 6'b0);
    vc_in_good = 0; step(); vc_in_good = 1;
    await_enable("R8", 3'b000);

    // start event and fault on the same edge: fault wins
    vc_in_good = 0; step();
    vc_in_good = 1; therm_sd = 1; step();
    therm_sd = 0; step(DLY + 4);
    chk("R6 R9 same-edge", {ind_pull, ind_oe}, 6'b0);

    // fault during the delay aborts it
    pulses(5); finish_cls(1'b0);
    vc_in_good = 0; step(); vc_in_good = 1; step(5);
    vcout_uv = 1; step(); vcout_uv = 0; step(DLY + 4);
    chk("R9 abort", {ind_pull, ind_oe}, 6'b0);
    pg_released = 1;
    await_enable("R5 R9", 3'b110);
    // restart: pg re-release mid-delay restarts count
    pg_released = 0; supply_low = 1; step(); supply_low = 0; step();
    pg_released = 1; step(5); pg_released = 0; step(); pg_released = 1;
    await_enable("R5 restart", 3'b110);
    pg_released = 0; vc_in_good = 0; step(2);

    // randomised rounds
    for (int r = 0; r < 24; r++) begin
      int n;
      logic t;
      logic [2:0] e;
      n = $urandom % 8;
      t = $urandom % 2;
      mark_reset();
      pulses(n);
      finish_cls(t);
      pulses($urandom % 3);
      e = exp_pull(n, t);
      vc_in_good = 1;
      await_enable($sformatf("R1 R2 R3 n=%0d", n), e);
      case ($urandom % 3)
        0: therm_sd = 1;
        1: vcout_uv = 1;
        default: supply_low = 1;
      endcase
      step();
      chk("R6 fault", {ind_pull, ind_oe}, 6'b0);
      step($urandom % 3);
      therm_sd = 0; vcout_uv = 0; supply_low = 0;
      step(3);
      chk("R9 stays off", {ind_pull, ind_oe}, 6'b0);
      pg_released = 1;
      await_enable("R7 R5 restore", e);
      chk("R10 pull within oe", {3'b000, ind_pull & ~ind_oe}, 6'b0);
      vc_in_good = 0; pg_released = 0; step(2);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule